// File: doc/BRIEF.md
# Private Countdown Timer

A per-processor countdown timer controlled through four 32-bit registers on a plain synchronous register bus. Software writes a starting count, picks a prescale factor and a mode, and enables the timer. While it runs, the counter steps down once per prescaled period. When it expires it sets a sticky status flag, and the rising edge of that flag sends a one-cycle request to a private interrupt line. In one-shot mode the counter stops at zero. In auto-reload mode it restarts from the stored reload value.

Every register access finishes in the cycle it is presented. The bus has no valid/ready pair and no back-pressure: a write with `sel_i` and `we_i` high takes effect at the next rising clock edge. A read with `sel_i` high and `we_i` low returns data combinationally in the same cycle. The interrupt output is a plain level that is high for one cycle per event. A bus decoder above the block selects which instance is addressed.

Top module: `priv_tick_timer`

## Requirements
- R1: After reset, the reload value, counter, control word and status read as zero, and `irq_o` is low.
- R2: `addr_i` is a byte offset: 0x0 is the reload value, 0x4 the counter, 0x8 the control word and 0xC the status. Control reads back the whole word that was written. Any other offset reads zero, and writes to it change nothing. `rdata_o` is zero unless a read is presented.
- R3: A write to 0x0 stores the value as the reload value and also places it in the counter. A write to 0x4 changes only the counter.
- R4: A read of 0x4 returns zero whenever control bit 0 is clear or the count is zero.
- R5: Control bit 0 enables counting. Bits [15:8] hold a prescale value P. While the timer is enabled with a nonzero count, the counter decreases by one every (P+1)*BASE_DIV clock cycles.
- R6: When the counter steps down from 1, status bit 0 is set. If control bit 1 is clear (one-shot), the counter then stays at zero and stops.
- R7: If control bit 1 is set (auto-reload), expiry reloads the counter from the reload value, and counting continues.
- R8: A control write that takes bit 0 from 0 to 1 first copies the reload value into the counter, but only if the count is zero and bit 1 is set in the written word. Otherwise the counter is left as it is.
- R9: A write to 0xC with bit 0 at 1 clears the status, and bit 0 at 0 leaves it alone. If an expiry happens in the same cycle as a clear, the expiry wins.
- R10: `irq_o` is high for exactly the one cycle after status goes from 0 to 1. An expiry while the status is already set gives no pulse.
- R11: A write to 0x0 or 0x4, or an enabling control write, restarts the prescaler. The next decrement then comes a full (P+1)*BASE_DIV cycles after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, same cycle |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with DATA_W=32, PRESC_W=8 and BASE_DIV=2. With BASE_DIV=2, every period is even, and a prescaler that ignores the base divider, or is off by one, shifts the expiry edge by a countable number of cycles. Small random prescale values (0 to 3) and counts (1 to 6) keep each expiry within a few dozen cycles, so many full countdowns fit in the run. A prescale of 0xFF holds the counter still long enough to read back register writes.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam logic [3:0] OFF_RELOAD = 4'h0;
  localparam logic [3:0] OFF_COUNT  = 4'h4;
  localparam logic [3:0] OFF_CTRL   = 4'h8;
  localparam logic [3:0] OFF_STAT   = 4'hC;

  localparam int BIT_EN   = 0;
  localparam int BIT_AUTO = 1;
  localparam int PRE_LSB  = 8;

  typedef struct packed {
    logic reload;
    logic count;
    logic ctrl;
    logic stat;
  } wr_strobe_t;
endpackage

// File: rtl/ptt_prescaler.sv
module ptt_prescaler #(
  parameter int PRESC_W  = 8,
  parameter int BASE_DIV = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               restart_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  localparam int BD_W  = (BASE_DIV > 1) ? $clog2(BASE_DIV) + 1 : 1;
  localparam int LIM_W = PRESC_W + BD_W + 1;

  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] cnt_q;
  logic             wrap;

  generate
    if (BASE_DIV == 1) begin : g_nodiv
      assign limit = LIM_W'(presc_i);
    end else begin : g_div
      assign limit = LIM_W'((LIM_W'(presc_i) + LIM_W'(1)) * LIM_W'(BASE_DIV) - LIM_W'(1));
    end
  endgenerate

  assign wrap   = (cnt_q >= limit);
  assign tick_o = run_i && !restart_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || !run_i || wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + LIM_W'(1);
    end
  end
endmodule

// File: rtl/ptt_counter.sv
module ptt_counter
  import ptt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_strobe_t        wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] reload_o,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              status_o,
  output logic              run_o,
  output logic              restart_o
);
  logic [DATA_W-1:0] reload_q, count_q, ctrl_q;
  logic              status_q;
  logic              en_rise, expire, count_zero;

  assign count_zero = (count_q == '0);
  assign en_rise    = wr_i.ctrl && !ctrl_q[BIT_EN] && wdata_i[BIT_EN];
  assign restart_o  = wr_i.reload || wr_i.count || en_rise;
  assign run_o      = ctrl_q[BIT_EN] && !count_zero;
  assign expire     = tick_i && (count_q == DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
    end else if (wr_i.reload) begin
      reload_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i.ctrl) begin
      ctrl_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (wr_i.reload || wr_i.count) begin
      count_q <= wdata_i;
    end else if (en_rise && count_zero && wdata_i[BIT_AUTO]) begin
      count_q <= reload_q;
    end else if (expire) begin
      count_q <= ctrl_q[BIT_AUTO] ? reload_q : '0;
    end else if (tick_i) begin
      count_q <= count_q - DATA_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
    end else if (expire) begin
      status_q <= 1'b1;
    end else if (wr_i.stat && wdata_i[0]) begin
      status_q <= 1'b0;
    end
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign ctrl_o   = ctrl_q;
  assign status_o = status_q;
endmodule

// File: rtl/ptt_irq_edge.sv
module ptt_irq_edge #(
  parameter int FLAG_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              irq_o
);
  logic [FLAG_W-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
    end else begin
      seen_q <= flags_i;
    end
  end

  assign irq_o = |(flags_i & ~seen_q);
endmodule

// File: rtl/priv_tick_timer.sv
module priv_tick_timer
  import ptt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PRESC_W  = 8,
  parameter int BASE_DIV = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  wr_strobe_t        wr;
  logic [DATA_W-1:0] reload_q, count_q, ctrl_q;
  logic              status_q, run, restart, tick;
  logic              do_wr, do_rd;

  assign do_wr     = sel_i && we_i;
  assign do_rd     = sel_i && !we_i;
  assign wr.reload = do_wr && (addr_i == OFF_RELOAD);
  assign wr.count  = do_wr && (addr_i == OFF_COUNT);
  assign wr.ctrl   = do_wr && (addr_i == OFF_CTRL);
  assign wr.stat   = do_wr && (addr_i == OFF_STAT);

  ptt_counter #(.DATA_W(DATA_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wdata_i   (wdata_i),
    .tick_i    (tick),
    .reload_o  (reload_q),
    .count_o   (count_q),
    .ctrl_o    (ctrl_q),
    .status_o  (status_q),
    .run_o     (run),
    .restart_o (restart)
  );

  ptt_prescaler #(.PRESC_W(PRESC_W), .BASE_DIV(BASE_DIV)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (restart),
    .presc_i   (ctrl_q[PRE_LSB +: PRESC_W]),
    .tick_o    (tick)
  );

  ptt_irq_edge #(.FLAG_W(1)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (status_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (do_rd) begin
      case (addr_i)
        OFF_RELOAD: rdata_o = reload_q;
        OFF_COUNT:  rdata_o = ctrl_q[BIT_EN] ? count_q : '0;
        OFF_CTRL:   rdata_o = ctrl_q;
        OFF_STAT:   rdata_o = DATA_W'(status_q);
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [3:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] reload_q,
  input logic [DATA_W-1:0] count_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              status_q,
  input logic              tick
);
  logic wr_cnt_or_load, wr_touch;
  assign wr_cnt_or_load = sel_i && we_i && (addr_i == 4'h0 || addr_i == 4'h4);
  assign wr_touch       = wr_cnt_or_load || (sel_i && we_i && addr_i == 4'h8);

  assert_irq_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_has_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_q);

  assert_reload_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == 4'h0) |=>
      (reload_q == $past(wdata_i) && count_q == $past(wdata_i)));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[0] && !wr_touch) |=> $stable(count_q));

  assert_status_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q) |-> ($past(count_q) == DATA_W'(1)));

  assert_oneshot_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && count_q == DATA_W'(1) && !ctrl_q[1] && !wr_cnt_or_load) |=> (count_q == '0));

  assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && !(addr_i inside {4'h0, 4'h4, 4'h8, 4'hC})) |-> (rdata_o == '0));

  assert_disabled_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i == 4'h4 && !ctrl_q[0]) |-> (rdata_o == '0));
endmodule

bind priv_tick_timer ptt_checker #(.DATA_W(DATA_W)) u_ptt_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .reload_q (reload_q),
  .count_q  (count_q),
  .ctrl_q   (ctrl_q),
  .status_q (status_q),
  .tick     (tick)
);

// File: tb/tb_priv_tick_timer.sv
`timescale 1ns/1ps
module tb_priv_tick_timer;
  localparam int DATA_W   = 32;
  localparam int PRESC_W  = 8;
  localparam int BASE_DIV = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sel_i = 1'b0;
  logic              we_i = 1'b0;
  logic [3:0]        addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  priv_tick_timer #(.DATA_W(DATA_W), .PRESC_W(PRESC_W), .BASE_DIV(BASE_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic int period(input int p);
    return (p + 1) * BASE_DIV;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    sel_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1;
    d = rdata_o;
    sel_i = 1'b0;
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);

    // R1 reset state
    rd(4'h0, v); chk("R1 reload", v, 0);
    rd(4'h4, v); chk("R1 counter", v, 0);
    rd(4'h8, v); chk("R1 control", v, 0);
    rd(4'hC, v); chk("R1 status", v, 0);
    chk("R1 irq", irq_o, 0);

    // R2 map and unmapped offsets
    wr(4'h8, 32'hA5A5_3A00);
    rd(4'h8, v); chk("R2 control readback", v, 32'hA5A5_3A00);
    wr(4'h2, 32'd5);
    rd(4'h2, v); chk("R2 unmapped read", v, 0);
    rd(4'h0, v); chk("R2 unmapped write ignored", v, 0);
    chk("R2 idle rdata", rdata_o, 0);
    wr(4'h0, 32'd77);
    rd(4'h0, v); chk("R2 reload readback", v, 77);
    rd(4'h4, v); chk("R4 counter read while disabled", v, 0);

    // R3 writes with a very slow prescaler
    wr(4'h8, 32'h0000_FF01);
    rd(4'h4, v); chk("R3 reload write set counter", v, 77);
    wr(4'h4, 32'd40);
    rd(4'h4, v); chk("R3 counter write", v, 40);
    rd(4'h0, v); chk("R3 counter write leaves reload", v, 77);
    wr(4'h0, 32'd90);
    rd(4'h4, v); chk("R3 reload write counter", v, 90);
    rd(4'h0, v); chk("R3 reload write reload", v, 90);
    wr(4'h8, 32'h0);
    rd(4'h4, v); chk("R4 disabled nonzero count reads 0", v, 0);

    // R5/R6 one-shot, P=2 (period 6)
    wr(4'h4, 32'd3);
    wr(4'h8, 32'h0000_0201);
    cyc(period(2)); rd(4'h4, v); chk("R5 first decrement", v, 2);
    cyc(period(2)); rd(4'h4, v); chk("R5 second decrement", v, 1);
    cyc(period(2) - 1); rd(4'hC, v); chk("R6 status before expiry", v, 0);
    chk("R10 irq before expiry", irq_o, 0);
    cyc(1); rd(4'hC, v); chk("R6 status at expiry", v, 1);
    chk("R10 irq pulse", irq_o, 1);
    rd(4'h4, v); chk("R4 zero count read", v, 0);
    cyc(1); chk("R10 irq single cycle", irq_o, 0);
    cyc(20); rd(4'h4, v); chk("R6 one-shot stays stopped", v, 0);
    rd(4'hC, v); chk("R6 status sticky", v, 1);

    // R9 status clear
    wr(4'hC, 32'h0);
    rd(4'hC, v); chk("R9 write 0 keeps status", v, 1);
    wr(4'hC, 32'h1);
    rd(4'hC, v); chk("R9 write 1 clears status", v, 0);
    chk("R10 no irq on clear", irq_o, 0);

    // R8 enable with zero count
    wr(4'h8, 32'h0);
    wr(4'h8, 32'h0000_0003);
    rd(4'h4, v); chk("R8 auto enable loads reload", v, 90);
    wr(4'h8, 32'h0);
    wr(4'h4, 32'h0);
    wr(4'h8, 32'h0000_0001);
    rd(4'h4, v); chk("R8 one-shot enable keeps zero", v, 0);
    cyc(10); rd(4'hC, v); chk("R8 no expiry from zero count", v, 0);

    // R7/R10 auto-reload, P=1 (period 4), reload 3
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd3);
    wr(4'h8, 32'h0000_0103);
    cyc(3 * period(1) - 1); rd(4'hC, v); chk("R7 status before first expiry", v, 0);
    cyc(1); rd(4'hC, v); chk("R7 first expiry", v, 1);
    chk("R10 first pulse", irq_o, 1);
    rd(4'h4, v); chk("R7 counter reloaded", v, 3);
    cyc(1); chk("R10 pulse ends", irq_o, 0);
    cyc(3 * period(1) - 2);
    cyc(1); chk("R10 no pulse while status set", irq_o, 0);
    rd(4'h4, v); chk("R7 counter reloaded again", v, 3);
    wr(4'hC, 32'h1);
    // cleared at expiry+2; next expiry 12 cycles after previous one
    cyc(3 * period(1) - 3); rd(4'hC, v); chk("R7 status before third expiry", v, 0);
    cyc(1); chk("R10 pulse after clear", irq_o, 1);
    rd(4'hC, v); chk("R7 third expiry", v, 1);
    wr(4'h8, 32'h0);

    // R11 prescaler restart on counter write, P=3 (period 8)
    wr(4'hC, 32'h1);
    wr(4'h4, 32'd3);
    wr(4'h8, 32'h0000_0301);
    cyc(5);
    wr(4'h4, 32'd2);
    cyc(2 * period(3) - 1); rd(4'hC, v); chk("R11 no early expiry", v, 0);
    cyc(1); rd(4'hC, v); chk("R11 expiry full periods after write", v, 1);
    wr(4'h8, 32'h0);

    // Random one-shot runs
    for (int it = 0; it < 12; it++) begin
      int p, n, t;
      p = int'($urandom % 4);
      n = 1 + int'($urandom % 6);
      t = period(p);
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h1);
      wr(4'h4, 32'(n));
      wr(4'h8, (32'(p) << 8) | 32'h1);
      if (n > 1) begin
        cyc(t); rd(4'h4, v); chk("R5 random decrement", v, 32'(n - 1));
        cyc((n - 1) * t - 1);
      end else begin
        cyc(t - 1);
      end
      rd(4'hC, v); chk("R6 random before expiry", v, 0);
      cyc(1); rd(4'hC, v); chk("R6 random expiry", v, 1);
      chk("R10 random pulse", irq_o, 1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule